// File: doc/BRIEF.md
# Fixed-Point Second-Order Resonant Band-Pass Section

This block is a recursive second-order filter section for integer datapaths. It accepts signed 8-bit converter samples, each marked by a one-cycle sample strobe. It produces a 24-bit signed filtered value one clock later, together with a valid flag. The coefficients are integer numerators over 256 and are fixed when the block is elaborated. The block spends one clock per sample. A new sample may arrive on every clock, or with any number of idle clocks between samples.

Each sample is first widened into the 24-bit working range by placing it 16 bits up, with sign extension. One difference equation forms the resonator state. It adds three products that are computed in parallel: the input gain times the scaled sample, the first feedback coefficient times the newest state, and the second feedback coefficient times the older state. The sum is kept at full width. An arithmetic shift right by 8 then divides it by 256, and the result is clamped to the 24-bit range. A second difference equation moves the newest state into the older-state register. Both registers load on the same strobe. The output is the difference of the two states, which places a zero at DC, and it is also clamped to 24 bits.

Top module: `iir_bp_section`

## Requirements
- R1: While reset is asserted and right after it, out_valid is 0, out_data is 0, and both state registers hold zero.
- R2: out_valid equals the in_valid of the previous clock, so every strobe gives exactly one valid cycle.
- R3: A clock with in_valid low changes neither state register, so out_data keeps its value.
- R4: The 8-bit two's-complement sample enters the arithmetic multiplied by 2^16: it is sign-extended into the 24-bit range with 16 zero bits below it.
- R5: On a strobe, the newest state becomes floor((B0·X + A1·W1 + A2·W2) / 256). X is the scaled sample, W1 is the newest state and W2 is the older state. The sum is formed at full width, and the division rounds toward negative infinity.
- R6: When the R5 quotient lies outside [-8388608, 8388607], the stored state is the nearer of those two limits. It does not wrap.
- R7: On a strobe, the older-state register takes the previous newest state. out_data equals newest minus older, clamped to [-8388608, 8388607].
- R8: All products of one update are formed in the same clock. The result of a strobe therefore appears on the next clock, even when strobes arrive back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 8 | Signed converter sample |
| out_valid | output | 1 | Marks a new output, one clock after the strobe |
| out_data | output | 24 | Signed filter output |

## Verification
The bench checks negative inputs whose quotients are not whole numbers. A design that truncated toward zero would come out one count high there. A second instance is built with aggressive coefficients, so that both the state and the output difference pass each rail. A design that wrapped instead of clamping would jump to the opposite sign. The bench puts idle gaps between strobes and also sends strobes back to back. A design that loaded the state registers without the strobe, or delayed the older-state register by a cycle, would drift or shift the output sequence.

// File: rtl/iir_bp_pkg.sv
package iir_bp_pkg;
  localparam int unsigned SAMPLE_W_DEF = 8;
  localparam int unsigned WORK_W_DEF   = 24;
  localparam int unsigned COEF_W_DEF   = 10;
  localparam int unsigned FRAC_W_DEF   = 8;
  localparam int unsigned NTERM        = 3;
  typedef enum logic [1:0] {TERM_IN = 2'd0, TERM_FB1 = 2'd1, TERM_FB2 = 2'd2} term_e;
endpackage

// File: rtl/iir_prescale.sv
module iir_prescale #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned WORK_W   = 24
) (
  input  logic signed [SAMPLE_W-1:0] smp,
  output logic signed [WORK_W-1:0]   scaled
);
  localparam int unsigned PAD_W = WORK_W - SAMPLE_W;
  assign scaled = {smp, {PAD_W{1'b0}}};
endmodule

// File: rtl/iir_mac.sv
module iir_mac #(
  parameter int unsigned WORK_W = 24,
  parameter int unsigned COEF_W = 10,
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned NT     = 3
) (
  input  logic signed [COEF_W-1:0] coef [NT],
  input  logic signed [WORK_W-1:0] opnd [NT],
  output logic signed [WORK_W-1:0] result,
  output logic                     clamped
);
  localparam int unsigned SUM_W = WORK_W + COEF_W + $clog2(NT) + 1;
  localparam logic signed [SUM_W-1:0] HI = {{(SUM_W-WORK_W+1){1'b0}}, {(WORK_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] LO = {{(SUM_W-WORK_W+1){1'b1}}, {(WORK_W-1){1'b0}}};

  logic signed [SUM_W-1:0] prod [NT];
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] quot;

  for (genvar i = 0; i < NT; i++) begin : g_prod
    assign prod[i] = SUM_W'(coef[i]) * SUM_W'(opnd[i]);
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NT; i++) sum = sum + prod[i];
  end

  assign quot = sum >>> FRAC_W;

  always_comb begin
    clamped = 1'b0;
    result  = quot[WORK_W-1:0];
    if (quot > HI) begin
      clamped = 1'b1;
      result  = HI[WORK_W-1:0];
    end else if (quot < LO) begin
      clamped = 1'b1;
      result  = LO[WORK_W-1:0];
    end
  end

  logic signed [SUM_W-1:0] rem;
  assign rem = sum - (SUM_W'(result) <<< FRAC_W);
  // R5
  always_comb begin
    if (!clamped) begin
      floor_rem_chk: assert (rem >= 0 && rem < (SUM_W'(1) <<< FRAC_W));
    end
  end
endmodule

// File: rtl/iir_state.sv
module iir_state #(
  parameter int unsigned WORK_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [WORK_W-1:0] nxt,
  output logic signed [WORK_W-1:0] cur_q,
  output logic signed [WORK_W-1:0] old_q
);
  logic signed [WORK_W-1:0] cur_d, old_d;

  always_comb begin
    cur_d = cur_q;
    old_d = old_q;
    if (en) begin
      cur_d = nxt;
      old_d = cur_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      old_q <= '0;
    end else begin
      cur_q <= cur_d;
      old_q <= old_d;
    end
  end

  // R7
  old_takes_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> old_q == $past(cur_q));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cur_q) && $stable(old_q)));
endmodule

// File: rtl/iir_bp_section.sv
module iir_bp_section
  import iir_bp_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned WORK_W   = WORK_W_DEF,
  parameter int unsigned COEF_W   = COEF_W_DEF,
  parameter int unsigned FRAC_W   = FRAC_W_DEF,
  parameter int          GAIN_B0  = 26,
  parameter int          FB_A1    = 230,
  parameter int          FB_A2    = -207
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  output logic [WORK_W-1:0]   out_data
);
  logic signed [WORK_W-1:0] x_scaled, w_next, w_cur, w_old;
  logic signed [COEF_W-1:0] coef_v [NTERM];
  logic signed [WORK_W-1:0] opnd_v [NTERM];
  logic                     w_clamped;
  logic                     vld_q, vld_d;
  logic signed [WORK_W:0]   diff;

  iir_prescale #(.SAMPLE_W(SAMPLE_W), .WORK_W(WORK_W)) u_pre (
    .smp(in_sample), .scaled(x_scaled));

  assign coef_v[TERM_IN]  = COEF_W'(GAIN_B0);
  assign coef_v[TERM_FB1] = COEF_W'(FB_A1);
  assign coef_v[TERM_FB2] = COEF_W'(FB_A2);
  assign opnd_v[TERM_IN]  = x_scaled;
  assign opnd_v[TERM_FB1] = w_cur;
  assign opnd_v[TERM_FB2] = w_old;

  iir_mac #(.WORK_W(WORK_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .NT(NTERM)) u_mac (
    .coef(coef_v), .opnd(opnd_v), .result(w_next), .clamped(w_clamped));

  iir_state #(.WORK_W(WORK_W)) u_state (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .nxt(w_next),
    .cur_q(w_cur), .old_q(w_old));

  assign diff = {w_cur[WORK_W-1], w_cur} - {w_old[WORK_W-1], w_old};

  always_comb begin
    if (diff[WORK_W] != diff[WORK_W-1])
      out_data = diff[WORK_W] ? {1'b1, {(WORK_W-1){1'b0}}} : {1'b0, {(WORK_W-1){1'b1}}};
    else
      out_data = diff[WORK_W-1:0];
  end

  assign vld_d = in_valid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end
  assign out_valid = vld_q;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
endmodule

// File: tb/iir_bp_section_bench.sv
module iir_bp_section_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [7:0] in_sample;
  logic ov_a, ov_b;
  logic [23:0] od_a, od_b;
  int errors = 0;
  int checks = 0;
  longint wa1 = 0, wa2 = 0, wb1 = 0, wb2 = 0;

  always #2.5 clk = ~clk;

  iir_bp_section u_iir_bp_section (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(ov_a), .out_data(od_a));

  iir_bp_section #(.GAIN_B0(511), .FB_A1(511), .FB_A2(0)) u_hot (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(ov_b), .out_data(od_b));

  function automatic longint clamp24(longint v);
    if (v > 8388607) return 8388607;
    if (v < -8388608) return -8388608;
    return v;
  endfunction

  function automatic longint floor256(longint v);
    longint q = v / 256;
    if (v < 0 && (v % 256) != 0) q = q - 1;
    return q;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(string req, bit v, int x);
    longint xs, n;
    in_valid  = v;
    in_sample = 8'(x);
    @(posedge clk);
    if (v) begin
      xs = longint'(x) * 65536;
      n = clamp24(floor256(26 * xs + 230 * wa1 - 207 * wa2));
      wa2 = wa1; wa1 = n;
      n = clamp24(floor256(511 * xs + 511 * wb1));
      wb2 = wb1; wb1 = n;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R2 valid"}, longint'(ov_a), longint'(v));
    check({req, " data"}, longint'($signed(od_a)), clamp24(wa1 - wa2));
    check({req, " hot data"}, longint'($signed(od_b)), clamp24(wb1 - wb2));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
    repeat (3) @(negedge clk);
    check("R1 valid", longint'(ov_a), 0);
    check("R1 data", longint'($signed(od_a)), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 data after release", longint'($signed(od_b)), 0);
  endtask

  task automatic t_impulse();
    step("R4 R5 impulse", 1'b1, 1);
    for (int i = 0; i < 8; i++) step("R5 R8 ringing", 1'b1, 0);
  endtask

  task automatic t_gaps();
    step("R7 gap start", 1'b1, 50);
    for (int i = 0; i < 3; i++) step("R3 idle hold", 1'b0, 0);
    step("R7 gap resume", 1'b1, -3);
    step("R3 idle after", 1'b0, 77);
  endtask

  task automatic t_negative();
    step("R5 floor neg", 1'b1, -128);
    step("R5 floor neg", 1'b1, -1);
    step("R5 floor neg", 1'b1, -77);
    step("R5 floor mix", 1'b1, 3);
    for (int i = 0; i < 4; i++) step("R8 back to back", 1'b1, -5);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 6; i++) step("R6 R7 clamp high", 1'b1, 127);
    for (int i = 0; i < 6; i++) step("R6 R7 clamp low", 1'b1, -128);
    step("R6 recover", 1'b1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_impulse();
    t_gaps();
    t_negative();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule